// File: doc/BRIEF.md
# Receive Write-Burst Bus Master with Edge Alignment

This block drains a byte-wide receive FIFO into a host buffer. It issues master write cycles on a shared 32-bit multiplexed address/data bus. Software-side logic loads a buffer start address and a byte count with a one-cycle start pulse. The block then asks for the bus whenever the FIFO holds more than a low watermark and enough bytes for the next data phase. It emits an address phase followed by one or more data phases. It stops when the buffer is full, and signals completion with a one-cycle pulse.

Buffers may begin and end at any byte address. The opening data phase covers only the bytes up to the next 32-bit boundary. The closing phase covers only what is left. Every phase in between carries a whole, aligned word. A mode input chooses between single transfers and bursts. In single-transfer mode, every data phase gets its own address phase. In burst mode, a burst goes on for as long as the FIFO can feed the next phase without dropping to the watermark.

Top module: `rx_burst_dma_master`

## Requirements
- R1: While rst_ni is low, bus_req_o, cyc_o, dvalid_o, fifo_pop_o and done_o are 0, and lane_en_o is 4'b0000.
- R2: bus_req_o is high only when a transfer is active, no bus phase is in progress, fifo_level_i exceeds low_wm_i, and fifo_level_i is at least the byte count of the next data phase. The cycle after bus_req_o and bus_gnt_i are both high is an address phase, with cyc_o=1 and dvalid_o=0. In that phase bus_o carries the current byte address in single mode, and the same address with bits [1:0] forced to 00 in burst mode.
- R3: A data phase that starts at byte offset o = address[1:0] enables lanes o up to min(3, o+remaining-1) only. Lane k of lane_en_o (active high) maps to address offset k, so offset 1 gives 4'b1110.
- R4: A data phase that starts at offset 0 with at least 4 bytes remaining enables all four lanes (4'b1111). Every burst phase that is not the final one ends on a word boundary.
- R5: A closing phase with r < 4 bytes left at offset 0 enables lanes 0..r-1 only. For example, 9 bytes from an aligned start give 1111, 1111, 0001.
- R6: In a data phase, bus_o lane o+k carries FIFO byte k, where fifo_data_i[7:0] is the oldest byte. Lanes that are not enabled read 0.
- R7: A data phase completes only on a cycle with tgt_rdy_i high. While tgt_rdy_i is low, dvalid_o stays high and bus_o and lane_en_o hold their values.
- R8: Successive data phases cover contiguous, ascending byte addresses. Each address phase carries the address that follows the last byte written.
- R9: With burst_en_i=0 at start, each data phase follows its own address phase, and cyc_o is low throughout every data phase.
- R10: With burst_en_i=1, cyc_o stays high from the address phase through every data phase except the final one of the burst. After that final phase completes, dvalid_o is low in the next cycle.
- R11: A burst phase is non-final only if, after it, bytes remain in the buffer and the FIFO level (as seen when the phase starts, less that phase's bytes) is at least the next phase's byte count and above low_wm_i.
- R12: done_o pulses for one cycle, in the cycle after the phase that writes the buffer's last byte completes. The block then returns to idle.
- R13: fifo_pop_o is high exactly on completing data-phase cycles. fifo_pop_cnt_o then gives that phase's byte count, and otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; latches address, length and mode |
| buf_addr_i | input | 32 | Buffer start byte address |
| buf_len_i | input | LEN_W | Buffer length in bytes (nonzero) |
| burst_en_i | input | 1 | 1 selects burst mode, 0 single transfers |
| low_wm_i | input | LVL_W | FIFO low watermark |
| fifo_level_i | input | LVL_W | Bytes held in the receive FIFO |
| fifo_data_i | input | 32 | Oldest four FIFO bytes, oldest in [7:0] |
| fifo_pop_o | output | 1 | Remove bytes from the FIFO this cycle |
| fifo_pop_cnt_o | output | 3 | Number of bytes to remove |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| cyc_o | output | 1 | Transaction frame |
| dvalid_o | output | 1 | Initiator data phase valid |
| tgt_rdy_i | input | 1 | Target ready |
| bus_o | output | 32 | Multiplexed address/data |
| lane_en_o | output | 4 | Byte lane enables, active high |
| done_o | output | 1 | Buffer complete pulse |

## Verification
The assertions take several things about the inputs for granted. The FIFO's visible head bytes change only through this block's pops, and new bytes are appended behind them. fifo_level_i never drops except by a pop the block requested. Start comes only while idle and with a nonzero length. Low watermark and mode stay steady during a transfer. The bench meets these conditions with a queue-based FIFO model. It appends at the tail on falling edges, removes bytes only on sampled pops, and changes the watermark and mode only between transfers. Its ready and grant patterns stall phases and delay grants without breaking these rules.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  localparam int BUS_W  = 32;
  localparam int LANES  = BUS_W / 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int CNT_W  = OFF_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_DATA
  } rbd_state_e;
endpackage

// File: rtl/rbd_phase_plan.sv
module rbd_phase_plan
  import rbd_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int LVL_W = 6
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [LEN_W-1:0] rem_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] wm_i,
  output logic [CNT_W-1:0] n_o,
  output logic [LANES-1:0] be_o,
  output logic             more_o
);
  logic [CNT_W-1:0] room;
  logic [LEN_W-1:0] rem_after;
  logic [CNT_W-1:0] n_next;
  logic [LVL_W-1:0] lvl_after;
  logic [LANES:0]   mask;

  always_comb begin
    room      = CNT_W'(LANES) - CNT_W'(off_i);
    n_o       = (rem_i < LEN_W'(room)) ? rem_i[CNT_W-1:0] : room;
    mask      = (LANES+1)'((1 << n_o) - 1);
    be_o      = LANES'(mask[LANES-1:0] << off_i);
    rem_after = rem_i - LEN_W'(n_o);
    // following phase is word aligned whenever bytes remain
    n_next    = (rem_after >= LEN_W'(LANES)) ? CNT_W'(LANES) : rem_after[CNT_W-1:0];
    lvl_after = (lvl_i >= LVL_W'(n_o)) ? lvl_i - LVL_W'(n_o) : '0;
    more_o    = (rem_after != '0) && (lvl_after >= LVL_W'(n_next)) && (lvl_after > wm_i);
  end
endmodule

// File: rtl/rbd_lane_align.sv
module rbd_lane_align
  import rbd_pkg::*;
(
  input  logic [BUS_W-1:0] data_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [LANES-1:0] be_i,
  output logic [BUS_W-1:0] data_o
);
  logic [BUS_W-1:0] shifted;

  assign shifted = data_i << {off_i, 3'b000};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data_o[8*g +: 8] = be_i[g] ? shifted[8*g +: 8] : 8'h00;
  end
endmodule

// File: rtl/rx_burst_dma_master.sv
module rx_burst_dma_master
  import rbd_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int LVL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BUS_W-1:0] buf_addr_i,
  input  logic [LEN_W-1:0] buf_len_i,
  input  logic             burst_en_i,
  input  logic [LVL_W-1:0] low_wm_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic [BUS_W-1:0] fifo_data_i,
  output logic             fifo_pop_o,
  output logic [CNT_W-1:0] fifo_pop_cnt_o,
  output logic             bus_req_o,
  input  logic             bus_gnt_i,
  output logic             cyc_o,
  output logic             dvalid_o,
  input  logic             tgt_rdy_i,
  output logic [BUS_W-1:0] bus_o,
  output logic [LANES-1:0] lane_en_o,
  output logic             done_o
);
  rbd_state_e       state_q;
  logic [BUS_W-1:0] addr_q;
  logic [LEN_W-1:0] rem_q;
  logic             burst_q, last_q, done_q;

  logic [CNT_W-1:0] n_cur, n_nxt;
  logic [LANES-1:0] be_cur, be_nxt;
  logic             more_cur, more_nxt;
  logic [BUS_W-1:0] addr_nxt;
  logic [LEN_W-1:0] rem_nxt;
  logic [LVL_W-1:0] lvl_nxt;
  logic [BUS_W-1:0] data_al;
  logic             can_go, complete, finish;

  assign addr_nxt = addr_q + BUS_W'(n_cur);
  assign rem_nxt  = rem_q - LEN_W'(n_cur);
  assign lvl_nxt  = (fifo_level_i >= LVL_W'(n_cur)) ? fifo_level_i - LVL_W'(n_cur) : '0;

  rbd_phase_plan #(.LEN_W(LEN_W), .LVL_W(LVL_W)) i_plan_cur (
    .off_i (addr_q[OFF_W-1:0]),
    .rem_i (rem_q),
    .lvl_i (fifo_level_i),
    .wm_i  (low_wm_i),
    .n_o   (n_cur),
    .be_o  (be_cur),
    .more_o(more_cur)
  );

  // phase after the one completing now, seen with the post-pop level
  rbd_phase_plan #(.LEN_W(LEN_W), .LVL_W(LVL_W)) i_plan_nxt (
    .off_i (addr_nxt[OFF_W-1:0]),
    .rem_i (rem_nxt),
    .lvl_i (lvl_nxt),
    .wm_i  (low_wm_i),
    .n_o   (n_nxt),
    .be_o  (be_nxt),
    .more_o(more_nxt)
  );

  rbd_lane_align i_align (
    .data_i(fifo_data_i),
    .off_i (addr_q[OFF_W-1:0]),
    .be_i  (be_cur),
    .data_o(data_al)
  );

  assign can_go   = (fifo_level_i > low_wm_i) && (fifo_level_i >= LVL_W'(n_cur));
  assign complete = (state_q == ST_DATA) && tgt_rdy_i;
  assign finish   = complete && (rem_q == LEN_W'(n_cur));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      burst_q <= 1'b0;
      last_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          addr_q  <= buf_addr_i;
          rem_q   <= buf_len_i;
          burst_q <= burst_en_i;
          state_q <= ST_REQ;
        end
        ST_REQ: if (bus_req_o && bus_gnt_i) state_q <= ST_ADDR;
        ST_ADDR: begin
          last_q  <= !(burst_q && more_cur);
          state_q <= ST_DATA;
        end
        ST_DATA: if (tgt_rdy_i) begin
          addr_q <= addr_nxt;
          rem_q  <= rem_nxt;
          if (finish)      state_q <= ST_IDLE;
          else if (last_q) state_q <= ST_REQ;
          else             last_q  <= !(burst_q && more_nxt);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req_o      = (state_q == ST_REQ) && can_go;
    cyc_o          = (state_q == ST_ADDR) || ((state_q == ST_DATA) && !last_q);
    dvalid_o       = (state_q == ST_DATA);
    lane_en_o      = dvalid_o ? be_cur : '0;
    fifo_pop_o     = complete;
    fifo_pop_cnt_o = complete ? n_cur : '0;
    done_o         = done_q;
    if (state_q == ST_ADDR)
      bus_o = burst_q ? {addr_q[BUS_W-1:OFF_W], {OFF_W{1'b0}}} : addr_q;
    else if (state_q == ST_DATA)
      bus_o = data_al;
    else
      bus_o = '0;
  end

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dvalid_o && !tgt_rdy_i |=> dvalid_o && $stable(bus_o) && $stable(lane_en_o));

  assert_addr_after_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_o && !dvalid_o |-> $past(bus_req_o && bus_gnt_i));

  assert_mid_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dvalid_o && cyc_o |-> lane_en_o[LANES-1] && be_nxt[0]);

  assert_no_overdraw_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o && cyc_o |-> fifo_level_i >= LVL_W'(n_cur) + LVL_W'(n_nxt));

  assert_burst_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dvalid_o && tgt_rdy_i && !cyc_o |=> !dvalid_o);

  assert_single_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dvalid_o && !burst_q |-> !cyc_o);

  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o && !cyc_o && !dvalid_o && $past(fifo_pop_o));
endmodule

// File: tb/test_rx_burst_dma_master.sv
module test_rx_burst_dma_master;
  localparam int LEN_W = 16;
  localparam int LVL_W = 6;
  localparam int FMAX  = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             start_i = 0, burst_en_i = 0, bus_gnt_i = 0, tgt_rdy_i = 0;
  logic [31:0]      buf_addr_i = '0;
  logic [LEN_W-1:0] buf_len_i = '0;
  logic [LVL_W-1:0] low_wm_i = '0, fifo_level_i = '0;
  logic [31:0]      fifo_data_i = '0;
  logic             fifo_pop_o, bus_req_o, cyc_o, dvalid_o, done_o;
  logic [2:0]       fifo_pop_cnt_o;
  logic [31:0]      bus_o;
  logic [3:0]       lane_en_o;

  rx_burst_dma_master #(.LEN_W(LEN_W), .LVL_W(LVL_W)) i_rx_burst_dma_master (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .buf_addr_i, .buf_len_i, .burst_en_i,
    .low_wm_i, .fifo_level_i, .fifo_data_i, .fifo_pop_o, .fifo_pop_cnt_o,
    .bus_req_o, .bus_gnt_i, .cyc_o, .dvalid_o, .tgt_rdy_i, .bus_o, .lane_en_o, .done_o
  );

  logic [7:0] fq[$];
  int push_total = 0, pop_total = 0, vectors = 0, errors = 0, cyc_n = 0;
  int push_every = 0, trdy_mode = 0, gnt_mode = 0;

  // reference model state
  bit m_active = 0, m_burst = 0, exp_done = 0;
  bit prev_grant = 0, prev_addr = 0, prev_cont = 0, prev_hold = 0, exp_frame = 0;
  int m_addr = 0, m_rem = 0, m_wm = 0, prev_lvl_after = 0;
  logic [31:0] prev_bus;
  logic [3:0]  prev_be;

  function automatic logic [31:0] peek();
    logic [31:0] v = '0;
    for (int k = 0; k < 4; k++) if (k < fq.size()) v[8*k +: 8] = fq[k];
    return v;
  endfunction

  function automatic int nph(int a, int r);
    int room = 4 - (a % 4);
    return (r < room) ? r : room;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc_n);
    end
  endtask

  always @(posedge clk) begin
    if (fifo_pop_o) begin
      for (int k = 0; k < int'(fifo_pop_cnt_o); k++) void'(fq.pop_front());
      pop_total += int'(fifo_pop_cnt_o);
      fifo_level_i <= LVL_W'(fq.size());
      fifo_data_i  <= peek();
    end
  end

  task automatic model_check();
    int n, off, lvl, r_after, la, n2;
    bit exp_req, exp_irdy, new_ph, more;
    logic [3:0] be_e;
    logic [31:0] a_e;
    string tg;
    lvl = int'(fifo_level_i);
    chk(done_o == exp_done, "R12 done pulse", 32'(done_o), 32'(exp_done));
    exp_done = 0;
    n    = nph(m_addr, m_rem);
    off  = m_addr % 4;
    be_e = 4'(((1 << n) - 1) << off);
    exp_irdy = prev_addr || prev_cont || prev_hold;
    exp_req  = m_active && !exp_irdy && !prev_grant && (lvl > m_wm) && (lvl >= n);
    chk(bus_req_o == exp_req, "R2 request", 32'(bus_req_o), 32'(exp_req));
    if (prev_grant) begin
      a_e = m_burst ? (32'(m_addr) & ~32'h3) : 32'(m_addr);
      chk(cyc_o && !dvalid_o, "R2 address phase", {cyc_o, dvalid_o}, 32'b10);
      chk(bus_o == a_e, "R2 R8 address", bus_o, a_e);
    end
    chk(dvalid_o == exp_irdy, "R9 R10 data valid", 32'(dvalid_o), 32'(exp_irdy));
    prev_lvl_after = lvl;
    if (exp_irdy) begin
      new_ph = !prev_hold;
      if (new_ph) begin
        r_after = m_rem - n;
        la = prev_lvl_after_saved - n;
        n2 = (r_after >= 4) ? 4 : r_after;
        more = (r_after > 0) && (la >= n2) && (la > m_wm);
        exp_frame = m_burst && more;
      end else begin
        chk(bus_o == prev_bus && lane_en_o == prev_be, "R7 hold", bus_o, prev_bus);
      end
      tg = (off != 0) ? "R3 lanes" : (m_rem < 4) ? "R5 lanes" : "R4 lanes";
      chk(lane_en_o == be_e, tg, 32'(lane_en_o), 32'(be_e));
      a_e = '0;
      for (int k = 0; k < n; k++) a_e[8*(off+k) +: 8] = 8'(pop_total + k);
      chk(bus_o == a_e, "R6 data", bus_o, a_e);
      chk(cyc_o == exp_frame, m_burst ? "R10 R11 frame" : "R9 frame", 32'(cyc_o), 32'(exp_frame));
      chk(fifo_pop_o == tgt_rdy_i && int'(fifo_pop_cnt_o) == (tgt_rdy_i ? n : 0),
          "R13 pop", {fifo_pop_o, 5'b0, fifo_pop_cnt_o}, 32'(tgt_rdy_i ? n : 0));
      prev_bus = bus_o;
      prev_be  = lane_en_o;
      prev_hold = !tgt_rdy_i;
      prev_cont = 0;
      if (tgt_rdy_i) begin
        prev_lvl_after = lvl - n;
        m_addr += n;
        m_rem  -= n;
        prev_cont = exp_frame;
        if (m_rem == 0) begin
          m_active = 0;
          exp_done = 1;
        end
      end
    end else begin
      chk(!fifo_pop_o, "R13 no pop", 32'(fifo_pop_o), 0);
      if (!prev_grant) chk(!cyc_o, "R9 frame idle", 32'(cyc_o), 0);
      prev_hold = 0;
      prev_cont = 0;
    end
    prev_lvl_after_saved = prev_lvl_after;
    prev_addr  = prev_grant;
    prev_grant = exp_req && bus_gnt_i;
  endtask

  int prev_lvl_after_saved = 0;

  task automatic cycle(input bit do_start);
    @(negedge clk);
    cyc_n++;
    if (push_every > 0 && (cyc_n % push_every) == 0 && fq.size() < FMAX) begin
      fq.push_back(8'(push_total));
      push_total++;
    end
    fifo_level_i = LVL_W'(fq.size());
    fifo_data_i  = peek();
    tgt_rdy_i = (trdy_mode == 0) ? 1'b1 : ((cyc_n % 3) != 0);
    bus_gnt_i = (gnt_mode == 0) ? 1'b1 : ((cyc_n % 4) == 0);
    start_i   = do_start;
    #1;
    model_check();
  endtask

  task automatic run(input int addr, input int len, input bit burst, input int wm,
                     input int preload, input int pe, input int tm, input int gm);
    int guard = 0;
    push_every = pe; trdy_mode = tm; gnt_mode = gm;
    for (int k = 0; k < preload && fq.size() < FMAX; k++) begin
      fq.push_back(8'(push_total));
      push_total++;
    end
    buf_addr_i = 32'(addr); buf_len_i = LEN_W'(len);
    burst_en_i = burst; low_wm_i = LVL_W'(wm);
    cycle(1'b1);
    m_active = 1; m_burst = burst; m_addr = addr; m_rem = len; m_wm = wm;
    while ((m_active || exp_done) && guard < 3000) begin
      cycle(1'b0);
      guard++;
    end
    if (guard >= 3000) begin
      errors++;
      $display("FAIL R12 transfer timeout actual=%0d expected=0", m_rem);
      m_active = 0;
    end
    cycle(1'b0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      chk(!bus_req_o && !cyc_o && !dvalid_o && !fifo_pop_o && !done_o && lane_en_o == 4'b0,
          "R1 reset", {bus_req_o, cyc_o, dvalid_o, fifo_pop_o, done_o, lane_en_o}, 0);
    end
    rst_n = 1'b1;
    cycle(1'b0);
    // R3 R4 R5: offset 1, 13 bytes -> 1110,1111,1111,0011 in one burst
    run(32'h1001, 13, 1, 0, 20, 0, 0, 0);
    // R5: aligned, 9 bytes -> 1111,1111,0001
    run(32'h2000, 9, 1, 0, 9, 0, 0, 0);
    // R9: single transfers with own address phases
    run(32'h3002, 7, 0, 0, 8, 0, 0, 0);
    // R11: starved FIFO breaks bursts, ready stalls exercise R7
    run(32'h4000, 16, 1, 2, 0, 3, 1, 0);
    // R3: two bytes inside one word
    run(32'h5001, 2, 1, 0, 4, 0, 0, 0);
    // single byte at the top lane, delayed grants
    run(32'h6003, 1, 0, 0, 1, 0, 0, 1);
    // R8 R10: long burst, higher watermark, stalls and grant delays
    run(32'h7002, 20, 1, 5, 6, 2, 1, 1);
    // single mode with stalls over several words
    run(32'h8001, 11, 0, 1, 0, 2, 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule